// File: doc/BRIEF.md
# PWM Output-Level Controller

This block decides the pin levels of one complementary PWM output pair, a forward phase and a reverse phase, inside a motor-control timer. The counters, the compare logic and the dead-time generator sit outside; their results reach the block as single-cycle strobes and level flags. The block keeps two 2-bit polarity settings, one per phase. A live register decides the pins now. A buffer register holds the next setting until a counter event copies it into the live register. A 2-bit transfer code chooses which event does the copy, and the choice also depends on the PWM mode in use (complementary or reset-synchronized).

When the polarity enable bit is clear, the pins repeat two default-level inputs. When the enable bit is set, each phase tracks a logical active/inactive flag. The pin takes the active level when the flag is 1 and the inactive level when it is 0. A compare match while counting up makes the phase active. A compare match while counting down makes it inactive. A polarity bit of 0 makes the inactive level high and the active level low; a polarity bit of 1 swaps both.

A small run-state machine has three states: `ST_IDLE` (counter stopped), `ST_DEAD` (counting, dead time not yet elapsed) and `ST_LIVE` (counting, dead time elapsed). Its transitions are:
- IDLE→DEAD when counting starts with a non-zero dead time.
- IDLE→LIVE when counting starts with zero dead time.
- DEAD→LIVE when the dead-time-elapsed flag is seen.
- DEAD→IDLE and LIVE→IDLE when counting stops.

The reverse phase holds its inactive level through `ST_DEAD` and becomes active on entry to `ST_LIVE`. When the dead time is zero, the reverse pin is the inverse of the forward pin.

Top module: `pwm_level_ctl`

## Requirements
- R1: After reset the live register, the buffer register, the enable bit and the transfer code are all 0, `cfg_err` is 0, and both pins are 0 while reset is held.
- R2: With transfer code 00, counter events never copy the buffer into the live register, in either PWM mode.
- R3: With transfer code 01, the buffer is copied at `ev_crest` in complementary mode (`mode_rsync`=0) and at `ev_clear` in reset-synchronized mode (`mode_rsync`=1). No other event copies it.
- R4: In complementary mode, transfer code 10 copies the buffer at `ev_trough` only, and code 11 copies it at both `ev_crest` and `ev_trough`.
- R5: In reset-synchronized mode, codes 10 and 11 perform no copy. They set `cfg_err`, which stays 1 until the next register write (any `wr_sel` other than 00) clears it.
- R6: When a transfer event and a live-register write happen in the same cycle, the live register takes the buffer value.
- R7: With the enable bit at 0, `pin_fwd` and `pin_rev` follow `dflt_fwd` and `dflt_rev`, and the level registers have no effect on them.
- R8: With the enable bit at 1, a phase whose polarity bit is 0 outputs high when inactive and low when active; a polarity bit of 1 inverts both levels. A compare match while counting up (`cnt_down`=0) makes the phase active, and one while counting down makes it inactive. In `ST_IDLE` both phases are inactive.
- R9: In `ST_DEAD` the reverse phase stays inactive and ignores `cm_rev`. It becomes active in the cycle the state enters `ST_LIVE`.
- R10: With `dt_zero`=1 and the enable bit at 1, `pin_rev` is the inverse of `pin_fwd`.
- R11: The pins are registered. They change at the first rising edge after the compare match, transfer event or write that causes the change, and not before it.
- R12: When `cnt_run` falls, the state returns to `ST_IDLE` and both phases go back to their inactive levels.
- Register writes use `wr_sel`: 01 writes the live register, 10 the buffer, 11 the control register. For live and buffer writes, `wr_data[0]` is the forward polarity and `wr_data[1]` the reverse polarity. For control writes, `wr_data[0]` is the enable bit and `wr_data[2:1]` the transfer code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_sel | input | 2 | Write target: 00 none, 01 live, 10 buffer, 11 control |
| wr_data | input | 3 | Write data |
| mode_rsync | input | 1 | 1 = reset-synchronized PWM, 0 = complementary PWM |
| cnt_run | input | 1 | Counter is running |
| cnt_down | input | 1 | Counter direction, 1 = down |
| ev_crest | input | 1 | Counter crest strobe |
| ev_trough | input | 1 | Counter trough strobe |
| ev_clear | input | 1 | Counter clear strobe |
| dt_done | input | 1 | Dead time has elapsed since the counter started |
| dt_zero | input | 1 | Dead time is configured as zero |
| cm_fwd | input | 1 | Compare-match strobe, forward phase |
| cm_rev | input | 1 | Compare-match strobe, reverse phase |
| dflt_fwd | input | 1 | Default level, forward pin |
| dflt_rev | input | 1 | Default level, reverse pin |
| pin_fwd | output | 1 | Forward-phase pin level |
| pin_rev | output | 1 | Reverse-phase pin level |
| cfg_err | output | 1 | Sticky prohibited-transfer-code flag |

## Verification
A wrong live-register value shows at the pins in the cycle after the enable bit is set, because the idle inactive level is a direct function of each polarity bit. A missed or spurious transfer therefore shows one clock after the counter event. A run state stuck in `ST_DEAD`, or one that skips it, shows on `pin_rev` one clock after `dt_done` or after counting starts. A wrong activity flag shows at the next compare match, or at the next return to `ST_IDLE`. A missing sticky error shows on `cfg_err` one clock after the first idle cycle with a prohibited code, or one clock after the clearing write.

// File: rtl/pwm_lvl_pkg.sv
package pwm_lvl_pkg;
    localparam int NPH    = 2;
    localparam int PH_FWD = 0;
    localparam int PH_REV = 1;
    localparam int XM_W   = 2;
    localparam int CTL_W  = XM_W + 1;
    localparam int WR_W   = (CTL_W > NPH) ? CTL_W : NPH;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_LIVE = 2'd1,
        WR_BUF  = 2'd2,
        WR_CTL  = 2'd3
    } wr_sel_e;

    typedef enum logic [XM_W-1:0] {
        XF_OFF    = 2'd0,
        XF_PEAK   = 2'd1,
        XF_VALLEY = 2'd2,
        XF_BOTH   = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEAD = 2'd1,
        ST_LIVE = 2'd2
    } run_st_e;
endpackage

// File: rtl/pwm_lvl_regs.sv
module pwm_lvl_regs
    import pwm_lvl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  wr_sel_e         wr_sel,
    input  logic [WR_W-1:0] wr_data,
    input  logic            mode_rsync,
    input  logic            ev_crest,
    input  logic            ev_trough,
    input  logic            ev_clear,
    output logic [NPH-1:0]  lvl_q,
    output logic [NPH-1:0]  lvl_nxt,
    output logic [NPH-1:0]  buf_q,
    output logic            en_q,
    output logic            en_nxt,
    output xfer_e           xmode_q,
    output logic            cfg_err
);
    logic  xfer_hit;
    logic  bad_cfg;
    xfer_e xmode_nxt;

    // Transfer point decode, depends on PWM mode
    always_comb begin
        xfer_hit = 1'b0;
        unique case (xmode_q)
            XF_OFF:    xfer_hit = 1'b0;
            XF_PEAK:   xfer_hit = mode_rsync ? ev_clear : ev_crest;
            XF_VALLEY: xfer_hit = !mode_rsync && ev_trough;
            XF_BOTH:   xfer_hit = !mode_rsync && (ev_crest || ev_trough);
            default:   xfer_hit = 1'b0;
        endcase
    end

    assign bad_cfg = mode_rsync && ((xmode_q == XF_VALLEY) || (xmode_q == XF_BOTH));

    // Transfer wins over a CPU write to the live register
    always_comb begin
        lvl_nxt = lvl_q;
        if (xfer_hit)
            lvl_nxt = buf_q;
        else if (wr_sel == WR_LIVE)
            lvl_nxt = wr_data[NPH-1:0];
    end

    always_comb begin
        en_nxt    = en_q;
        xmode_nxt = xmode_q;
        if (wr_sel == WR_CTL) begin
            en_nxt    = wr_data[0];
            xmode_nxt = xfer_e'(wr_data[XM_W:1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            buf_q   <= '0;
            en_q    <= 1'b0;
            xmode_q <= XF_OFF;
            cfg_err <= 1'b0;
        end else begin
            lvl_q   <= lvl_nxt;
            en_q    <= en_nxt;
            xmode_q <= xmode_nxt;
            if (wr_sel == WR_BUF)
                buf_q <= wr_data[NPH-1:0];
            if (wr_sel != WR_NONE)
                cfg_err <= 1'b0;
            else if (bad_cfg)
                cfg_err <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_lvl_fsm.sv
module pwm_lvl_fsm
    import pwm_lvl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cnt_run,
    input  logic    dt_done,
    input  logic    dt_zero,
    output run_st_e st_q,
    output run_st_e st_nxt,
    output logic    enter_live
);
    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_nxt;
    end

    // Next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (cnt_run) st_nxt = dt_zero ? ST_LIVE : ST_DEAD;
            ST_DEAD: begin
                if (!cnt_run)
                    st_nxt = ST_IDLE;
                else if (dt_done || dt_zero)
                    st_nxt = ST_LIVE;
            end
            ST_LIVE: if (!cnt_run) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        enter_live = (st_nxt == ST_LIVE) && (st_q != ST_LIVE);
    end
endmodule

// File: rtl/pwm_lvl_phase.sv
module pwm_lvl_phase
    import pwm_lvl_pkg::*;
#(
    parameter bit DELAYED = 1'b0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  run_st_e st_nxt,
    input  logic    enter_live,
    input  logic    cm,
    input  logic    cnt_down,
    output logic    act_nxt
);
    logic act_q;

    // Logical active flag: 1 = active level, 0 = inactive (initial) level
    always_comb begin
        act_nxt = act_q;
        if (st_nxt == ST_IDLE)
            act_nxt = 1'b0;
        else if (DELAYED && (st_nxt == ST_DEAD))
            act_nxt = 1'b0;
        else if (DELAYED && enter_live)
            act_nxt = 1'b1;
        else if (cm)
            act_nxt = !cnt_down;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            act_q <= 1'b0;
        else
            act_q <= act_nxt;
    end
endmodule

// File: rtl/pwm_level_ctl.sv
module pwm_level_ctl
    import pwm_lvl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      wr_sel,
    input  logic [WR_W-1:0] wr_data,
    input  logic            mode_rsync,
    input  logic            cnt_run,
    input  logic            cnt_down,
    input  logic            ev_crest,
    input  logic            ev_trough,
    input  logic            ev_clear,
    input  logic            dt_done,
    input  logic            dt_zero,
    input  logic            cm_fwd,
    input  logic            cm_rev,
    input  logic            dflt_fwd,
    input  logic            dflt_rev,
    output logic            pin_fwd,
    output logic            pin_rev,
    output logic            cfg_err
);
    logic [NPH-1:0] lvl_q, lvl_nxt, buf_q;
    logic           en_q, en_nxt;
    xfer_e          xmode_q;
    run_st_e        st_q, st_nxt;
    logic           enter_live;
    logic [NPH-1:0] act_nxt;
    logic [NPH-1:0] cm_vec, dflt_vec;
    logic [NPH-1:0] pin_nxt, pin_q;

    assign cm_vec   = {cm_rev, cm_fwd};
    assign dflt_vec = {dflt_rev, dflt_fwd};

    pwm_lvl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel_e'(wr_sel)),
        .wr_data    (wr_data),
        .mode_rsync (mode_rsync),
        .ev_crest   (ev_crest),
        .ev_trough  (ev_trough),
        .ev_clear   (ev_clear),
        .lvl_q      (lvl_q),
        .lvl_nxt    (lvl_nxt),
        .buf_q      (buf_q),
        .en_q       (en_q),
        .en_nxt     (en_nxt),
        .xmode_q    (xmode_q),
        .cfg_err    (cfg_err)
    );

    pwm_lvl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_run    (cnt_run),
        .dt_done    (dt_done),
        .dt_zero    (dt_zero),
        .st_q       (st_q),
        .st_nxt     (st_nxt),
        .enter_live (enter_live)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        pwm_lvl_phase #(
            .DELAYED (p == PH_REV)
        ) u_phase (
            .clk        (clk),
            .rst_n      (rst_n),
            .st_nxt     (st_nxt),
            .enter_live (enter_live),
            .cm         (cm_vec[p]),
            .cnt_down   (cnt_down),
            .act_nxt    (act_nxt[p])
        );
    end

    // Map activity and polarity onto pin levels; polarity 0 = active low
    always_comb begin
        for (int p = 0; p < NPH; p++) begin
            if (en_nxt)
                pin_nxt[p] = act_nxt[p] ? lvl_nxt[p] : ~lvl_nxt[p];
            else
                pin_nxt[p] = dflt_vec[p];
        end
        if (en_nxt && dt_zero)
            pin_nxt[PH_REV] = ~pin_nxt[PH_FWD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin_q <= '0;
        else
            pin_q <= pin_nxt;
    end

    assign pin_fwd = pin_q[PH_FWD];
    assign pin_rev = pin_q[PH_REV];
endmodule

// File: rtl/pwm_level_chk.sv
module pwm_level_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] wr_sel,
    input logic       mode_rsync,
    input logic       cnt_run,
    input logic       ev_crest,
    input logic       ev_trough,
    input logic       ev_clear,
    input logic       dt_done,
    input logic       dt_zero,
    input logic       dflt_fwd,
    input logic       dflt_rev,
    input logic       pin_fwd,
    input logic       pin_rev,
    input logic       cfg_err,
    input logic [1:0] lvl_q,
    input logic [1:0] buf_q,
    input logic       en_q,
    input logic [1:0] xmode_q,
    input logic [1:0] st_q
);
    p_no_xfer_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xmode_q == 2'd0 && wr_sel != 2'd1) |=> $stable(lvl_q));

    p_crest_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xmode_q == 2'd1 && !mode_rsync && ev_crest) |=> (lvl_q == $past(buf_q)));

    p_clear_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xmode_q == 2'd1 && mode_rsync && ev_clear) |=> (lvl_q == $past(buf_q)));

    p_trough_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xmode_q[1] && !mode_rsync && ev_trough) |=> (lvl_q == $past(buf_q)));

    p_bad_cfg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rsync && xmode_q[1] && wr_sel == 2'd0) |=> cfg_err);

    p_bad_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rsync && xmode_q[1] && wr_sel != 2'd1) |=> $stable(lvl_q));

    p_dflt_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && wr_sel != 2'd3) |=>
        (pin_fwd == $past(dflt_fwd) && pin_rev == $past(dflt_rev)));

    p_dead_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == 2'd1 && cnt_run && !dt_done && !dt_zero && en_q && wr_sel != 2'd3)
        |=> (pin_rev == ~lvl_q[1]));

    p_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && dt_zero && wr_sel != 2'd3) |=> (pin_rev != pin_fwd));
endmodule

bind pwm_level_ctl pwm_level_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (wr_sel),
    .mode_rsync (mode_rsync),
    .cnt_run    (cnt_run),
    .ev_crest   (ev_crest),
    .ev_trough  (ev_trough),
    .ev_clear   (ev_clear),
    .dt_done    (dt_done),
    .dt_zero    (dt_zero),
    .dflt_fwd   (dflt_fwd),
    .dflt_rev   (dflt_rev),
    .pin_fwd    (pin_fwd),
    .pin_rev    (pin_rev),
    .cfg_err    (cfg_err),
    .lvl_q      (lvl_q),
    .buf_q      (buf_q),
    .en_q       (en_q),
    .xmode_q    (xmode_q),
    .st_q       (st_q)
);

// File: tb/test_pwm_level_ctl.sv
module test_pwm_level_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [2:0] wr_data = '0;
    logic mode_rsync = 0, cnt_run = 0, cnt_down = 0;
    logic ev_crest = 0, ev_trough = 0, ev_clear = 0;
    logic dt_done = 0, dt_zero = 0, cm_fwd = 0, cm_rev = 0;
    logic dflt_fwd = 0, dflt_rev = 0;
    logic pin_fwd, pin_rev, cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwm_level_ctl i_pwm_level_ctl (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .mode_rsync(mode_rsync), .cnt_run(cnt_run), .cnt_down(cnt_down),
        .ev_crest(ev_crest), .ev_trough(ev_trough), .ev_clear(ev_clear),
        .dt_done(dt_done), .dt_zero(dt_zero), .cm_fwd(cm_fwd), .cm_rev(cm_rev),
        .dflt_fwd(dflt_fwd), .dflt_rev(dflt_rev),
        .pin_fwd(pin_fwd), .pin_rev(pin_rev), .cfg_err(cfg_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // pins checked as {pin_rev, pin_fwd}
    task automatic chk_pins(input string req, input logic [1:0] exp);
        n_chk++;
        if ({pin_rev, pin_fwd} !== exp) begin
            n_fail++;
            $display("FAIL %s pins got=%b exp=%b", req, {pin_rev, pin_fwd}, exp);
        end
    endtask

    task automatic chk_err(input string req, input logic exp);
        n_chk++;
        if (cfg_err !== exp) begin
            n_fail++;
            $display("FAIL %s cfg_err got=%b exp=%b", req, cfg_err, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [2:0] data);
        wr_sel  = sel;
        wr_data = data;
        step();
        wr_sel  = 2'b00;
        wr_data = '0;
    endtask

    task automatic t_reset();
        dflt_fwd = 1'b1;
        dflt_rev = 1'b0;
        repeat (2) step();
        chk_pins("R1 reset pins", 2'b00);
        chk_err("R1 reset err", 1'b0);
        rst_n = 1'b1;
        step();
        chk_pins("R1 R7 default after reset", 2'b01);
        wr(2'b11, 3'b001);                 // enable, transfer code 00
        chk_pins("R1 live reset zero gives high", 2'b11);
    endtask

    task automatic t_xfer_none();
        wr(2'b10, 3'b011);                 // buffer = 11
        ev_crest = 1; ev_trough = 1; ev_clear = 1;
        step();
        ev_crest = 0; ev_trough = 0; ev_clear = 0;
        chk_pins("R2 no copy complementary", 2'b11);
        mode_rsync = 1;
        ev_crest = 1; ev_trough = 1; ev_clear = 1;
        step();
        ev_crest = 0; ev_trough = 0; ev_clear = 0;
        chk_pins("R2 no copy reset-sync", 2'b11);
        chk_err("R2 no error for code 00", 1'b0);
        mode_rsync = 0;
    endtask

    task automatic t_xfer_crest_clear();
        wr(2'b11, 3'b011);                 // enable, code 01
        ev_trough = 1; step(); ev_trough = 0;
        chk_pins("R3 trough ignored for code 01", 2'b11);
        ev_crest = 1;
        #1;
        chk_pins("R11 no change before edge", 2'b11);
        step(); ev_crest = 0;
        chk_pins("R3 R11 crest copies", 2'b00);
        wr(2'b01, 3'b000);
        chk_pins("R3 live rewrite", 2'b11);
        mode_rsync = 1;
        ev_crest = 1; step(); ev_crest = 0;
        chk_pins("R3 crest ignored reset-sync", 2'b11);
        ev_clear = 1; step(); ev_clear = 0;
        chk_pins("R3 clear copies reset-sync", 2'b00);
        mode_rsync = 0;
    endtask

    task automatic t_xfer_trough_both();
        wr(2'b01, 3'b000);
        wr(2'b11, 3'b101);                 // code 10
        ev_crest = 1; step(); ev_crest = 0;
        chk_pins("R4 crest ignored for code 10", 2'b11);
        ev_trough = 1; step(); ev_trough = 0;
        chk_pins("R4 trough copies", 2'b00);
        wr(2'b01, 3'b000);
        wr(2'b11, 3'b111);                 // code 11
        ev_crest = 1; step(); ev_crest = 0;
        chk_pins("R4 code 11 crest copies", 2'b00);
        wr(2'b01, 3'b000);
        ev_trough = 1; step(); ev_trough = 0;
        chk_pins("R4 code 11 trough copies", 2'b00);
    endtask

    task automatic t_rsync_bad();
        wr(2'b01, 3'b000);
        chk_pins("R5 setup", 2'b11);
        mode_rsync = 1;
        wr(2'b11, 3'b101);                 // code 10 while reset-sync
        chk_err("R5 cleared in write cycle", 1'b0);
        ev_crest = 1; ev_trough = 1; ev_clear = 1;
        step();
        ev_crest = 0; ev_trough = 0; ev_clear = 0;
        chk_pins("R5 no copy for prohibited code", 2'b11);
        chk_err("R5 error set", 1'b1);
        step();
        chk_err("R5 error sticky", 1'b1);
        wr(2'b11, 3'b011);                 // code 01
        chk_err("R5 error cleared by write", 1'b0);
        step();
        chk_err("R5 error stays clear", 1'b0);
        mode_rsync = 0;
    endtask

    task automatic t_priority();
        wr_sel = 2'b01; wr_data = 3'b000; ev_crest = 1;
        step();
        wr_sel = 2'b00; ev_crest = 0;
        chk_pins("R6 transfer wins over write", 2'b00);
        wr(2'b01, 3'b000);
        chk_pins("R6 plain write applies", 2'b11);
    endtask

    task automatic t_polarity();
        wr(2'b11, 3'b001);                 // code 00
        cnt_run = 1; step();
        chk_pins("R8 running inactive high", 2'b11);
        cm_fwd = 1; cnt_down = 0;
        #1;
        chk_pins("R11 no change before edge", 2'b11);
        step(); cm_fwd = 0;
        chk_pins("R8 R11 up match active low", 2'b10);
        step();
        chk_pins("R8 level held", 2'b10);
        cm_fwd = 1; cnt_down = 1; step(); cm_fwd = 0;
        chk_pins("R8 down match inactive high", 2'b11);
        wr(2'b01, 3'b001);                 // forward polarity 1
        chk_pins("R8 inverted inactive low", 2'b10);
        cm_fwd = 1; cnt_down = 0; step(); cm_fwd = 0;
        chk_pins("R8 inverted active high", 2'b11);
    endtask

    task automatic t_dead();
        wr(2'b01, 3'b000);
        chk_pins("R9 forward active low, reverse initial", 2'b10);
        cm_rev = 1; cnt_down = 0; step(); cm_rev = 0;
        chk_pins("R9 reverse ignores match in dead time", 2'b10);
        step();
        chk_pins("R9 reverse still initial", 2'b10);
        dt_done = 1; step();
        chk_pins("R9 reverse active after dead time", 2'b00);
        dt_done = 0;
        cm_rev = 1; cnt_down = 1; step(); cm_rev = 0;
        chk_pins("R9 reverse follows match when live", 2'b10);
    endtask

    task automatic t_stop();
        cnt_run = 0; step();
        chk_pins("R12 stop restores inactive", 2'b11);
    endtask

    task automatic t_deadzero();
        dt_zero = 1; step();
        chk_pins("R10 idle mirror", 2'b01);
        cnt_run = 1; step();
        chk_pins("R10 running mirror", 2'b01);
        cm_fwd = 1; cnt_down = 0; step(); cm_fwd = 0;
        chk_pins("R10 mirror on up match", 2'b10);
        cm_fwd = 1; cnt_down = 1; step(); cm_fwd = 0;
        chk_pins("R10 mirror on down match", 2'b01);
        cnt_run = 0; dt_zero = 0; step();
        chk_pins("R12 R10 back to idle", 2'b11);
    endtask

    task automatic t_default();
        wr(2'b11, 3'b000);                 // disable
        chk_pins("R7 defaults", 2'b01);
        dflt_fwd = 0; dflt_rev = 1; step();
        chk_pins("R7 defaults follow", 2'b10);
        wr(2'b01, 3'b011);
        cm_fwd = 1; step(); cm_fwd = 0;
        chk_pins("R7 level register no effect", 2'b10);
    endtask

    initial begin
        t_reset();
        t_xfer_none();
        t_xfer_crest_clear();
        t_xfer_trough_both();
        t_rsync_bad();
        t_priority();
        t_polarity();
        t_dead();
        t_stop();
        t_deadzero();
        t_default();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule